// File: doc/BRIEF.md
# Set-Associative Address Translation Cache

This block caches translations for a 32-bit virtual address space that uses 4 KB pages. Storage is organised as 16 sets of 4 ways, which gives 64 entries. Each entry holds one of two kinds of cached table entry: a leaf entry, which maps a page, or a directory entry, which gives the base address of a page table.

A lookup takes a virtual address and searches two sets in the same cycle: one for a leaf entry and one for a directory entry. A leaf match gives the physical address directly. If only the directory entry matches, the block reports a partial hit and supplies the page-table base, so the walker needs only one memory read instead of two. With no leaf match, the block raises a walk request in the same cycle.

The walker writes its results back through a fill port. Two flush inputs remove entries. The task-switch flush keeps entries marked global. The full flush clears every entry.

Top module: `tlb_top`

## Requirements
- R1: After reset no entry is valid: every lookup gives `lk_hit`=0 and `lk_dir_hit`=0, and it gives `lk_walk`=1.
- R2: A leaf entry is keyed by the virtual page number `va[31:12]`. Its set is `va[15:12]` and its tag is `va[31:16]`. All 64 entries, four in each of the 16 sets, can be held and hit at the same time.
- R3: A lookup that matches a leaf entry gives the following in the same cycle: `lk_hit`=1, `lk_walk`=0, `lk_paddr` = {entry[31:12], va[11:0]} and `lk_perm` = entry[11:0].
- R4: A lookup that matches no leaf entry gives `lk_hit`=0 and `lk_walk`=1 in the same cycle.
- R5: A directory entry is keyed by `va[31:22]`. Its set is `va[25:22]` and its tag is `va[31:26]`, zero-extended to 16 bits. A lookup with no leaf match but a directory match gives `lk_dir_hit`=1, `lk_table_base` = entry[31:12] and `lk_walk`=1.
- R6: A leaf lookup never matches a directory entry, even when the set and the tag are equal. The same holds the other way round.
- R7: A fill chooses its way in this order:
  - It overwrites in place a valid entry of the same kind and tag, and leaves the set's round-robin pointer unchanged.
  - Otherwise it uses the lowest-numbered invalid way, and the pointer again stays unchanged.
  - Otherwise it uses the way the pointer names, and the pointer then advances by one, modulo 4.
  
  A written entry can be hit from the next cycle on.
- R8: `flush_task` clears, in one cycle, every entry whose bit 8 (the global flag) is 0. Entries with bit 8 set stay valid.
- R9: `flush_all` clears every entry in one cycle, including global ones.
- R10: A fill that arrives in the same cycle as either flush is discarded.
- R11: If a lookup's leaf set or directory set equals the set of a fill in the same cycle, the block gives `lk_retry`=1 and forces `lk_hit`, `lk_dir_hit` and `lk_walk` to 0. The same lookup in the next cycle sees the filled entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_hit | output | 1 | Leaf entry matched |
| lk_dir_hit | output | 1 | Only a directory entry matched |
| lk_retry | output | 1 | Lookup blocked by a same-set fill |
| lk_walk | output | 1 | Walker must fetch the leaf entry |
| lk_paddr | output | 32 | Physical address on a leaf hit, else 0 |
| lk_perm | output | 12 | Low 12 bits of the hit leaf entry, else 0 |
| lk_table_base | output | 20 | Page-table base on a directory hit, else 0 |
| fill_valid | input | 1 | Write a walker result |
| fill_dir | input | 1 | 1 = directory entry, 0 = leaf entry |
| fill_vpn | input | 20 | Virtual page number of the result (bits 19:10 for a directory entry) |
| fill_entry | input | 32 | Table entry to cache |
| flush_task | input | 1 | Invalidate non-global entries |
| flush_all | input | 1 | Invalidate all entries |

## Verification
The no-duplicate assertion relies on a property of the inputs: the walker never fills a kind and key that is already cached other than through the fill port's in-place overwrite path. The stimulus keeps to this because every refill of an existing key goes through that path. The assertions also assume that flush and fill inputs are only sampled after reset is released. The bench drives inputs on falling edges only, which keeps within that. Lookups may sit on the port while fills and flushes occur, because the block guarantees that a lookup changes no stored state.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VA_W       = 32;
    localparam int OFF_W      = 12;
    localparam int VPN_W      = VA_W - OFF_W;
    localparam int DIR_W      = 10;
    localparam int SET_BITS   = 4;
    localparam int SETS       = 1 << SET_BITS;
    localparam int WAYS       = 4;
    localparam int WAY_BITS   = $clog2(WAYS);
    localparam int TAG_W      = VPN_W - SET_BITS;
    localparam int DTAG_W     = DIR_W - SET_BITS;
    localparam int ENT_W      = 32;
    localparam int PFN_W      = ENT_W - OFF_W;
    localparam int GLOBAL_BIT = 8;

    typedef struct packed {
        logic               is_dir;
        logic [TAG_W-1:0]   tag;
        logic [ENT_W-1:0]   pte;
    } entry_t;

    function automatic logic [SET_BITS-1:0] leaf_set(input logic [VPN_W-1:0] vpn);
        return vpn[SET_BITS-1:0];
    endfunction

    function automatic logic [TAG_W-1:0] leaf_tag(input logic [VPN_W-1:0] vpn);
        return vpn[VPN_W-1:SET_BITS];
    endfunction

    function automatic logic [SET_BITS-1:0] dir_set(input logic [VPN_W-1:0] vpn);
        return vpn[VPN_W-DIR_W+SET_BITS-1:VPN_W-DIR_W];
    endfunction

    function automatic logic [TAG_W-1:0] dir_tag(input logic [VPN_W-1:0] vpn);
        return TAG_W'(vpn[VPN_W-1:VPN_W-DTAG_W]);
    endfunction
endpackage

// File: rtl/tlb_way_match.sv
module tlb_way_match
    import tlb_pkg::*;
(
    input  logic [WAYS-1:0]    valid_i,
    input  entry_t [WAYS-1:0]  ent_i,
    input  logic               is_dir_i,
    input  logic [TAG_W-1:0]   tag_i,
    output logic [WAYS-1:0]    match_o,
    output logic [ENT_W-1:0]   pte_o,
    output logic               any_o
);
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match_o[w] = valid_i[w] && (ent_i[w].is_dir == is_dir_i)
                            && (ent_i[w].tag == tag_i);
    end

    always_comb begin
        pte_o = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match_o[w]) pte_o = pte_o | ent_i[w].pte;
        end
    end

    assign any_o = |match_o;
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim
    import tlb_pkg::*;
(
    input  logic [WAYS-1:0]     valid_i,
    input  logic [WAYS-1:0]     match_i,
    input  logic [WAY_BITS-1:0] rr_i,
    output logic [WAY_BITS-1:0] way_o,
    output logic                use_rr_o
);
    always_comb begin
        way_o    = rr_i;
        use_rr_o = 1'b1;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid_i[w]) begin
                way_o    = WAY_BITS'(w);
                use_rr_o = 1'b0;
            end
        end
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match_i[w]) begin
                way_o    = WAY_BITS'(w);
                use_rr_o = 1'b0;
            end
        end
    end
endmodule

// File: rtl/tlb_top.sv
module tlb_top
    import tlb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_vaddr,
    output logic              lk_hit,
    output logic              lk_dir_hit,
    output logic              lk_retry,
    output logic              lk_walk,
    output logic [VA_W-1:0]   lk_paddr,
    output logic [OFF_W-1:0]  lk_perm,
    output logic [PFN_W-1:0]  lk_table_base,
    input  logic              fill_valid,
    input  logic              fill_dir,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [ENT_W-1:0]  fill_entry,
    input  logic              flush_task,
    input  logic              flush_all
);
    typedef struct packed {
        logic [SETS-1:0][WAYS-1:0]      valid;
        entry_t [SETS-1:0][WAYS-1:0]    ent;
        logic [SETS-1:0][WAY_BITS-1:0]  rr;
    } state_t;

    state_t st_d, st_q;

    // lookup keys
    logic [VPN_W-1:0]    lk_vpn;
    logic [SET_BITS-1:0] p_set, d_set, f_set;
    logic [TAG_W-1:0]    p_tag, d_tag, f_tag;
    assign lk_vpn = lk_vaddr[VA_W-1:OFF_W];
    assign p_set  = leaf_set(lk_vpn);
    assign p_tag  = leaf_tag(lk_vpn);
    assign d_set  = dir_set(lk_vpn);
    assign d_tag  = dir_tag(lk_vpn);
    assign f_set  = fill_dir ? dir_set(fill_vpn) : leaf_set(fill_vpn);
    assign f_tag  = fill_dir ? dir_tag(fill_vpn) : leaf_tag(fill_vpn);

    logic [WAYS-1:0]  p_match, d_match, f_match;
    logic [ENT_W-1:0] p_pte, d_pte, f_pte_unused;
    logic             p_any, d_any, f_any;

    tlb_way_match u_leaf_match (
        .valid_i (st_q.valid[p_set]), .ent_i (st_q.ent[p_set]),
        .is_dir_i(1'b0), .tag_i (p_tag),
        .match_o (p_match), .pte_o (p_pte), .any_o (p_any)
    );

    tlb_way_match u_dir_match (
        .valid_i (st_q.valid[d_set]), .ent_i (st_q.ent[d_set]),
        .is_dir_i(1'b1), .tag_i (d_tag),
        .match_o (d_match), .pte_o (d_pte), .any_o (d_any)
    );

    tlb_way_match u_fill_match (
        .valid_i (st_q.valid[f_set]), .ent_i (st_q.ent[f_set]),
        .is_dir_i(fill_dir), .tag_i (f_tag),
        .match_o (f_match), .pte_o (f_pte_unused), .any_o (f_any)
    );

    logic [WAY_BITS-1:0] vic_way;
    logic                vic_rr;

    tlb_victim u_victim (
        .valid_i (st_q.valid[f_set]), .match_i (f_match),
        .rr_i    (st_q.rr[f_set]),
        .way_o   (vic_way), .use_rr_o (vic_rr)
    );

    logic dir_low_unused;
    assign dir_low_unused = ^{d_pte[OFF_W-1:0], d_match};

    // lookup outputs
    always_comb begin
        lk_retry      = lk_valid && fill_valid && (f_set == p_set || f_set == d_set);
        lk_hit        = lk_valid && !lk_retry && p_any;
        lk_dir_hit    = lk_valid && !lk_retry && !p_any && d_any;
        lk_walk       = lk_valid && !lk_retry && !p_any;
        lk_paddr      = lk_hit ? {p_pte[ENT_W-1:OFF_W], lk_vaddr[OFF_W-1:0]} : '0;
        lk_perm       = lk_hit ? p_pte[OFF_W-1:0] : '0;
        lk_table_base = lk_dir_hit ? d_pte[ENT_W-1:OFF_W] : '0;
    end

    logic fill_go;
    assign fill_go = fill_valid && !flush_task && !flush_all;

    // next state
    always_comb begin
        st_d = st_q;
        if (flush_all) begin
            st_d.valid = '0;
        end else if (flush_task) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (!st_q.ent[s][w].pte[GLOBAL_BIT]) st_d.valid[s][w] = 1'b0;
                end
            end
        end else if (fill_valid) begin
            st_d.valid[f_set][vic_way]      = 1'b1;
            st_d.ent[f_set][vic_way].is_dir = fill_dir;
            st_d.ent[f_set][vic_way].tag    = f_tag;
            st_d.ent[f_set][vic_way].pte    = fill_entry;
            if (vic_rr) st_d.rr[f_set] = st_q.rr[f_set] + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // checking support
    logic nonglobal_live;
    always_comb begin
        nonglobal_live = 1'b0;
        for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < WAYS; w++) begin
                if (st_q.valid[s][w] && !st_q.ent[s][w].pte[GLOBAL_BIT]) nonglobal_live = 1'b1;
            end
        end
    end

    logic                arm_q;
    logic [SET_BITS-1:0] arm_set_q;
    logic [WAY_BITS:0]   arm_cnt_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_q     <= 1'b0;
            arm_set_q <= '0;
            arm_cnt_q <= '0;
        end else begin
            arm_q     <= fill_go && !f_any && !(&st_q.valid[f_set]);
            arm_set_q <= f_set;
            arm_cnt_q <= (WAY_BITS+1)'($countones(st_q.valid[f_set]));
        end
    end

    // R9: full flush leaves nothing valid
    assert_flush_all_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> (st_q.valid == '0));

    // R8: task flush leaves only global entries
    assert_task_keeps_global_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_task && !flush_all) |=> !nonglobal_live);

    // R7: a fill into a set with a free way grows that set by exactly one entry
    assert_fill_uses_free_way_R7: assert property (@(posedge clk) disable iff (!rst_n)
        arm_q |-> ($countones(st_q.valid[arm_set_q]) == int'(arm_cnt_q) + 1));

    // R6: a leaf key never matches more than one way
    assert_single_leaf_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(p_match));

    // R11: a blocked lookup reports nothing else
    assert_retry_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        lk_retry |-> !(lk_hit || lk_dir_hit || lk_walk));
endmodule

// File: tb/tlb_top_bench.sv
module tlb_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic        lk_hit, lk_dir_hit, lk_retry, lk_walk;
    logic [31:0] lk_paddr;
    logic [11:0] lk_perm;
    logic [19:0] lk_table_base;
    logic        fill_valid = 1'b0, fill_dir = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [31:0] fill_entry = '0;
    logic        flush_task = 1'b0, flush_all = 1'b0;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    tlb_top u_tlb_top (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .lk_hit(lk_hit), .lk_dir_hit(lk_dir_hit), .lk_retry(lk_retry), .lk_walk(lk_walk),
        .lk_paddr(lk_paddr), .lk_perm(lk_perm), .lk_table_base(lk_table_base),
        .fill_valid(fill_valid), .fill_dir(fill_dir), .fill_vpn(fill_vpn),
        .fill_entry(fill_entry), .flush_task(flush_task), .flush_all(flush_all)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] pte_of(input logic [19:0] v, input bit g);
        return {v ^ 20'hA5A5A, 3'b000, g, v[7:0]};
    endfunction

    task automatic fill(input bit dir, input logic [19:0] vpn, input logic [31:0] pte,
                        input bit ft, input bit fa);
        @(negedge clk);
        fill_valid = 1'b1; fill_dir = dir; fill_vpn = vpn; fill_entry = pte;
        flush_task = ft; flush_all = fa;
        @(negedge clk);
        fill_valid = 1'b0; flush_task = 1'b0; flush_all = 1'b0;
    endtask

    task automatic look(input logic [31:0] va);
        lk_valid = 1'b1;
        lk_vaddr = va;
        #2;
    endtask

    task automatic check_page(input logic [19:0] vpn, input bit exp_hit,
                              input logic [31:0] pte, input string req);
        logic [31:0] va;
        va = {vpn, vpn[11:0] ^ 12'h5A3};
        look(va);
        chk(lk_hit == exp_hit, req, 32'(lk_hit), 32'(exp_hit));
        chk(lk_walk == !exp_hit, req, 32'(lk_walk), 32'(!exp_hit));
        if (exp_hit) begin
            chk(lk_paddr == {pte[31:12], va[11:0]}, req, lk_paddr, {pte[31:12], va[11:0]});
            chk(lk_perm == pte[11:0], req, 32'(lk_perm), 32'(pte[11:0]));
        end
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #4000000;
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

    localparam logic [31:0] DPTE = 32'h1234_5007;
    localparam logic [31:0] NEW53 = 32'h0BEE_F053;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: empty after reset
        for (int v = 0; v < 40; v += 13) begin
            check_page(20'(v), 1'b0, '0, "R1 empty after reset");
            chk(lk_dir_hit == 1'b0, "R1 no dir hit", 32'(lk_dir_hit), 0);
        end

        // R2/R7: fill all 64 ways, lowest invalid way first
        for (int t = 1; t <= 4; t++)
            for (int s = 0; s < 16; s++)
                fill(1'b0, 20'(s + 16 * t), pte_of(20'(s + 16 * t), t == 1), 1'b0, 1'b0);
        // R2, R3: every entry hits with the right address and permission bits
        for (int t = 1; t <= 4; t++)
            for (int s = 0; s < 16; s++)
                check_page(20'(s + 16 * t), 1'b1, pte_of(20'(s + 16 * t), t == 1), "R2 R3 full table");

        // R5: directory entry partial hit (set 5, round-robin evicts way 0 = vpn 21)
        fill(1'b1, {10'h3C5, 10'h000}, DPTE, 1'b0, 1'b0);
        look({10'h3C5, 10'h155, 12'h000});
        chk(lk_dir_hit == 1'b1, "R5 dir hit", 32'(lk_dir_hit), 1);
        chk(lk_table_base == DPTE[31:12], "R5 table base", 32'(lk_table_base), 32'(DPTE[31:12]));
        chk(lk_walk == 1'b1 && lk_hit == 1'b0, "R4 R5 walk on partial hit", 32'({lk_walk, lk_hit}), 32'h2);

        // R6: leaf lookup with same set and tag as the directory entry misses
        look(32'h003C_5000);
        chk(lk_hit == 1'b0 && lk_dir_hit == 1'b0, "R6 kind isolation", 32'({lk_hit, lk_dir_hit}), 0);

        // R7: round-robin order in set 5
        check_page(20'd21, 1'b0, '0, "R7 rr evicted way0");
        check_page(20'd37, 1'b1, pte_of(20'd37, 1'b0), "R7 way1 kept");
        fill(1'b0, 20'd85, pte_of(20'd85, 1'b0), 1'b0, 1'b0);
        check_page(20'd37, 1'b0, '0, "R7 rr evicted way1");
        check_page(20'd53, 1'b1, pte_of(20'd53, 1'b0), "R7 way2 kept");
        fill(1'b0, 20'd53, NEW53, 1'b0, 1'b0);
        check_page(20'd53, 1'b1, NEW53, "R7 in-place overwrite");
        check_page(20'd69, 1'b1, pte_of(20'd69, 1'b0), "R7 no eviction on overwrite");
        fill(1'b0, 20'd101, pte_of(20'd101, 1'b0), 1'b0, 1'b0);
        check_page(20'd53, 1'b0, '0, "R7 pointer not advanced by overwrite");
        check_page(20'd69, 1'b1, pte_of(20'd69, 1'b0), "R7 way3 kept");
        check_page(20'd101, 1'b1, pte_of(20'd101, 1'b0), "R7 new fill");

        // R8 + R10: task flush with a concurrent fill into set 8
        fill(1'b0, 20'd200, pte_of(20'd200, 1'b0), 1'b1, 1'b0);
        check_page(20'd200, 1'b0, '0, "R10 fill dropped under task flush");
        for (int s = 0; s < 16; s++) begin
            if (s == 5) continue;
            check_page(20'(s + 16), 1'b1, pte_of(20'(s + 16), 1'b1), "R8 global survives");
            for (int t = 2; t <= 4; t++)
                check_page(20'(s + 16 * t), 1'b0, '0, "R8 non-global cleared");
        end
        check_page(20'd69, 1'b0, '0, "R8 set5 cleared");
        check_page(20'd85, 1'b0, '0, "R8 set5 cleared");
        look({10'h3C5, 10'h155, 12'h000});
        chk(lk_dir_hit == 1'b0, "R8 dir entry cleared", 32'(lk_dir_hit), 0);

        // R7: lowest invalid ways in set 0, then pointer still at way 0
        fill(1'b0, 20'd0, pte_of(20'd0, 1'b0), 1'b0, 1'b0);
        fill(1'b0, 20'd128, pte_of(20'd128, 1'b0), 1'b0, 1'b0);
        fill(1'b0, 20'd144, pte_of(20'd144, 1'b0), 1'b0, 1'b0);
        check_page(20'd16, 1'b1, pte_of(20'd16, 1'b1), "R7 free ways used first");
        check_page(20'd144, 1'b1, pte_of(20'd144, 1'b0), "R7 free way fill");
        fill(1'b0, 20'd160, pte_of(20'd160, 1'b0), 1'b0, 1'b0);
        check_page(20'd16, 1'b0, '0, "R7 full set evicts pointer way0");
        check_page(20'd160, 1'b1, pte_of(20'd160, 1'b0), "R7 replacement");
        check_page(20'd0, 1'b1, pte_of(20'd0, 1'b0), "R7 others kept");

        // R11: same-set fill blocks lookup for one cycle
        @(negedge clk);
        lk_valid = 1'b1; lk_vaddr = {20'd17, 12'h010};
        fill_valid = 1'b1; fill_dir = 1'b0; fill_vpn = 20'd33; fill_entry = pte_of(20'd33, 1'b0);
        #2;
        chk(lk_retry == 1'b1, "R11 retry on leaf set clash", 32'(lk_retry), 1);
        chk({lk_hit, lk_dir_hit, lk_walk} == 3'b000, "R11 outputs quiet", 32'({lk_hit, lk_dir_hit, lk_walk}), 0);
        @(negedge clk);
        fill_valid = 1'b0;
        #2;
        chk(lk_retry == 1'b0 && lk_hit == 1'b1, "R11 retry succeeds", 32'({lk_retry, lk_hit}), 1);
        check_page(20'd33, 1'b1, pte_of(20'd33, 1'b0), "R11 fill landed");

        @(negedge clk);
        lk_vaddr = 32'h00C0_2000;
        fill_valid = 1'b1; fill_dir = 1'b0; fill_vpn = 20'd3; fill_entry = pte_of(20'd3, 1'b0);
        #2;
        chk(lk_retry == 1'b1 && lk_walk == 1'b0, "R11 retry on dir set clash", 32'({lk_retry, lk_walk}), 2);
        @(negedge clk);
        lk_vaddr = {20'd18, 12'h000};
        fill_vpn = 20'd4; fill_entry = pte_of(20'd4, 1'b0);
        #2;
        chk(lk_retry == 1'b0 && lk_hit == 1'b1, "R11 no retry other set", 32'({lk_retry, lk_hit}), 1);
        @(negedge clk);
        fill_valid = 1'b0;

        // R9 + R10: full flush clears globals and drops the concurrent fill
        fill(1'b0, 20'd7, pte_of(20'd7, 1'b1), 1'b0, 1'b1);
        check_page(20'd7, 1'b0, '0, "R10 fill dropped under full flush");
        check_page(20'd17, 1'b0, '0, "R9 global cleared");
        check_page(20'd18, 1'b0, '0, "R9 global cleared");
        check_page(20'd33, 1'b0, '0, "R9 cleared");
        check_page(20'd3, 1'b0, '0, "R9 cleared");

        summary();
    end
endmodule